// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The resolver turns two groups of pending interrupt requests into one priority level and decides whether that level may interrupt the processor now. A software request word and an external request vector are scanned independently. Software requests occupy a contiguous band of bit positions and are renumbered into small levels that start at 1. External requests occupy a higher band and keep their bit position as their level. The result is compared against the current interrupt priority level. When an interrupt is accepted, a one-cycle trap pulse is raised and a summary of every pending request bit, together with the resolved level, is latched into status registers for the handler to read.

Evaluation is gated by an internal arm flag. The flag is set out of reset and by a return-from-exception strobe. Every evaluation consumes it, so requests that arrive later wait until the next rearm. An asynchronous-trap request cannot be resolved by this block. When it is present at evaluation time, the block raises an unsupported-condition flag and does not resolve the requests.

With default parameters, software bits 4 to 18 map to levels 1 to 15, external bits 20 to 30 map to levels 20 to 30, and levels are 5 bits wide.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request bit at position i inside the software band (bits 4..18) yields level i-3. Among several software bits, the highest position wins.
- R2: An external request bit at position i inside the external band (bits 20..30) yields level i. Any pending external bit overrides every software bit. Among external bits, the highest position wins.
- R3: The summary is the OR of a one-hot bit at each pending position inside both bands, at the same bit position as the request. Request bits outside the bands (software bits 0..3 and 19..31, external bits 0..19 and 31) never affect the level, the summary or the trap.
- R4: An interrupt is taken only when the resolved level is nonzero and strictly greater than cur_ipl_i. An equal or lower level, or no pending request, gives no trap.
- R5: At the clock edge that takes an interrupt, summary_o and intid_o load the summary and the level. If no interrupt is taken, both hold their previous values.
- R6: trap_o is high for exactly one cycle, the cycle after the evaluating edge, unless a fresh evaluation follows.
- R7: If ast_req_i is high at an evaluating edge, unsupported_o is high for the following cycle, no trap is raised and the status registers hold.
- R8: The block evaluates only at edges where it is armed. It is armed after reset and after any cycle with rearm_i high. Each evaluation disarms it unless rearm_i is high in that same cycle.
- R9: While reset is asserted, trap_o, unsupported_o, summary_o and intid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_req_i | input | 32 | Software interrupt request word |
| ext_req_i | input | 32 | External interrupt request lines |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| rearm_i | input | 1 | Return-from-exception strobe that re-enables evaluation |
| ast_req_i | input | 1 | Asynchronous-trap request (unsupported) |
| trap_o | output | 1 | One-cycle interrupt trap pulse |
| summary_o | output | 32 | Captured pending-request summary |
| intid_o | output | 5 | Captured interrupt level |
| unsupported_o | output | 1 | Unsupported-condition flag |

## Verification
The bench sets a resolved level equal to the current priority level. A design that compares with greater-or-equal would trap there. It combines software and external requests so that a design that lets software win, or ranks by the lowest bit, would report the wrong level. Bits just outside each band are driven to catch an off-by-one band decoder, which would leak those bits into the summary or raise a spurious trap. Pending requests are presented without a rearm and together with an asynchronous-trap request. A design that evaluates continuously, or resolves despite that request, would trap or overwrite the status registers.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int REQ_W  = 32;
  localparam int LVL_W  = 5;
  localparam int SW_LO  = 4;
  localparam int SW_CNT = 15;
  localparam int EXT_LO = 20;
  localparam int EXT_CNT = 11;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [REQ_W-1:0] req_t;
endpackage

// File: rtl/irq_level_scan.sv
// Scans one contiguous band of a request word. COMPRESS selects the level
// numbering: 1 gives slot index + 1, 0 gives the raw bit position.
module irq_level_scan #(
  parameter int REQ_W    = 32,
  parameter int LVL_W    = 5,
  parameter int LO       = 4,
  parameter int CNT      = 15,
  parameter bit COMPRESS = 1'b1
) (
  input  logic [REQ_W-1:0] req,
  output logic [LVL_W-1:0] level,
  output logic             hit,
  output logic [REQ_W-1:0] mask
);
  logic [LVL_W-1:0] slot_lvl [CNT];

  for (genvar k = 0; k < CNT; k++) begin : g_slot
    if (COMPRESS) begin : g_cmp
      assign slot_lvl[k] = LVL_W'(k + 1);
    end else begin : g_raw
      assign slot_lvl[k] = LVL_W'(LO + k);
    end
  end

  // Ascending walk: the last hit (highest bit) sets the level.
  always_comb begin
    level = '0;
    hit   = 1'b0;
    mask  = '0;
    for (int k = 0; k < CNT; k++) begin
      if (req[LO+k]) begin
        level       = slot_lvl[k];
        hit         = 1'b1;
        mask[LO+k]  = 1'b1;
      end
    end
  end

  logic unused_req_bits;
  assign unused_req_bits = ^req;
endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int REQ_W = 32,
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             sw_hit,
  input  logic [REQ_W-1:0] sw_mask,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic             ext_hit,
  input  logic [REQ_W-1:0] ext_mask,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic             ast_req,
  output logic [LVL_W-1:0] res_lvl,
  output logic [REQ_W-1:0] res_sum,
  output logic             take,
  output logic             ast_err
);
  always_comb begin
    if (ext_hit)      res_lvl = ext_lvl;
    else if (sw_hit)  res_lvl = sw_lvl;
    else              res_lvl = '0;
    res_sum = sw_mask | ext_mask;
    ast_err = ast_req;
    take    = !ast_req && (res_lvl != '0) && (res_lvl > cur_ipl);
  end
endmodule

// File: rtl/irq_capture_regs.sv
module irq_capture_regs #(
  parameter int REQ_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic             take,
  input  logic             ast_err,
  input  logic [LVL_W-1:0] res_lvl,
  input  logic [REQ_W-1:0] res_sum,
  output logic             trap_q,
  output logic             unsup_q,
  output logic [REQ_W-1:0] sum_q,
  output logic [LVL_W-1:0] id_q
);
  logic             trap_d, unsup_d;
  logic [REQ_W-1:0] sum_d;
  logic [LVL_W-1:0] id_d;

  always_comb begin
    trap_d  = 1'b0;
    unsup_d = 1'b0;
    sum_d   = sum_q;
    id_d    = id_q;
    if (eval_en) begin
      if (ast_err) begin
        unsup_d = 1'b1;
      end else if (take) begin
        trap_d = 1'b1;
        sum_d  = res_sum;
        id_d   = res_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      unsup_q <= 1'b0;
      sum_q   <= '0;
      id_q    <= '0;
    end else begin
      trap_q  <= trap_d;
      unsup_q <= unsup_d;
      sum_q   <= sum_d;
      id_q    <= id_d;
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int P_REQ_W   = REQ_W,
  parameter int P_LVL_W   = LVL_W,
  parameter int P_SW_LO   = SW_LO,
  parameter int P_SW_CNT  = SW_CNT,
  parameter int P_EXT_LO  = EXT_LO,
  parameter int P_EXT_CNT = EXT_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_REQ_W-1:0] sw_req_i,
  input  logic [P_REQ_W-1:0] ext_req_i,
  input  logic [P_LVL_W-1:0] cur_ipl_i,
  input  logic               rearm_i,
  input  logic               ast_req_i,
  output logic               trap_o,
  output logic [P_REQ_W-1:0] summary_o,
  output logic [P_LVL_W-1:0] intid_o,
  output logic               unsupported_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Arm flag: set by rearm, consumed by each evaluation.
  logic armed_q, armed_d;
  always_comb begin
    armed_d = armed_q;
    if (armed_q) armed_d = 1'b0;
    if (rearm_i) armed_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed_q <= 1'b1;
    else            armed_q <= armed_d;
  end

  logic [P_LVL_W-1:0] sw_lvl, ext_lvl, res_lvl;
  logic               sw_hit, ext_hit, take, ast_err;
  logic [P_REQ_W-1:0] sw_mask, ext_mask, res_sum;

  irq_level_scan #(
    .REQ_W(P_REQ_W), .LVL_W(P_LVL_W), .LO(P_SW_LO), .CNT(P_SW_CNT), .COMPRESS(1'b1)
  ) u_sw_scan (
    .req(sw_req_i), .level(sw_lvl), .hit(sw_hit), .mask(sw_mask)
  );

  irq_level_scan #(
    .REQ_W(P_REQ_W), .LVL_W(P_LVL_W), .LO(P_EXT_LO), .CNT(P_EXT_CNT), .COMPRESS(1'b0)
  ) u_ext_scan (
    .req(ext_req_i), .level(ext_lvl), .hit(ext_hit), .mask(ext_mask)
  );

  irq_level_merge #(.REQ_W(P_REQ_W), .LVL_W(P_LVL_W)) u_merge (
    .sw_lvl(sw_lvl), .sw_hit(sw_hit), .sw_mask(sw_mask),
    .ext_lvl(ext_lvl), .ext_hit(ext_hit), .ext_mask(ext_mask),
    .cur_ipl(cur_ipl_i), .ast_req(ast_req_i),
    .res_lvl(res_lvl), .res_sum(res_sum), .take(take), .ast_err(ast_err)
  );

  irq_capture_regs #(.REQ_W(P_REQ_W), .LVL_W(P_LVL_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .eval_en(armed_q),
    .take(take), .ast_err(ast_err), .res_lvl(res_lvl), .res_sum(res_sum),
    .trap_q(trap_o), .unsup_q(unsupported_o), .sum_q(summary_o), .id_q(intid_o)
  );
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
  parameter int REQ_W   = 32,
  parameter int LVL_W   = 5,
  parameter int SW_LO   = 4,
  parameter int SW_CNT  = 15,
  parameter int EXT_LO  = 20,
  parameter int EXT_CNT = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] cur_ipl_i,
  input logic             armed,
  input logic             trap_o,
  input logic [REQ_W-1:0] summary_o,
  input logic [LVL_W-1:0] intid_o,
  input logic             unsupported_o
);
  function automatic logic [REQ_W-1:0] band(int lo, int cnt);
    logic [REQ_W-1:0] m;
    m = '0;
    for (int k = 0; k < REQ_W; k++) m[k] = (k >= lo) && (k < lo + cnt);
    return m;
  endfunction
  localparam logic [REQ_W-1:0] IN_BANDS = band(SW_LO, SW_CNT) | band(EXT_LO, EXT_CNT);

  // R4
  level_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (intid_o != '0) && (intid_o > $past(cur_ipl_i)));

  // R3
  summary_in_bands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ((summary_o & ~IN_BANDS) == '0) && (summary_o != '0));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(summary_o) && $stable(intid_o));

  // R7
  unsup_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |-> !trap_o);

  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !trap_o && !unsupported_o);

  // R6
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !armed) |=> !trap_o);
endmodule

bind irq_level_resolver irq_level_resolver_chk #(
  .REQ_W(P_REQ_W), .LVL_W(P_LVL_W), .SW_LO(P_SW_LO), .SW_CNT(P_SW_CNT),
  .EXT_LO(P_EXT_LO), .EXT_CNT(P_EXT_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_ipl_i(cur_ipl_i), .armed(armed_q),
  .trap_o(trap_o), .summary_o(summary_o), .intid_o(intid_o),
  .unsupported_o(unsupported_o)
);

// File: tb/irq_level_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_level_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sw_req, ext_req;
  logic [4:0]  cur_ipl;
  logic        rearm, ast_req;
  logic        trap;
  logic [31:0] summary;
  logic [4:0]  intid;
  logic        unsup;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_level_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .ext_req_i(ext_req),
    .cur_ipl_i(cur_ipl), .rearm_i(rearm), .ast_req_i(ast_req),
    .trap_o(trap), .summary_o(summary), .intid_o(intid), .unsupported_o(unsup)
  );

  typedef struct packed {
    logic [31:0] sw;
    logic [31:0] ext;
    logic [4:0]  ipl;
    logic        ast;
    logic        e_trap;
    logic        e_unsup;
    logic [4:0]  e_id;
    logic [31:0] e_sum;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 32'h0, 5'd0,  1'b0, 1'b1, 1'b0, 5'd1,  32'h0000_0010, 8'd1}, // R1 lowest sw bit
    '{32'h0004_0010, 32'h0, 5'd0,  1'b0, 1'b1, 1'b0, 5'd15, 32'h0004_0010, 8'd1}, // R1 highest wins
    '{32'h0004_0000, 32'h0, 5'd15, 1'b0, 1'b0, 1'b0, 5'd15, 32'h0004_0010, 8'd4}, // R4 equal -> none
    '{32'h0004_0000, 32'h0, 5'd14, 1'b0, 1'b1, 1'b0, 5'd15, 32'h0004_0000, 8'd4}, // R4 greater
    '{32'h0004_0000, 32'h0010_0000, 5'd0, 1'b0, 1'b1, 1'b0, 5'd20, 32'h0014_0000, 8'd2}, // R2 override
    '{32'h0, 32'h4010_0000, 5'd29, 1'b0, 1'b1, 1'b0, 5'd30, 32'h4010_0000, 8'd2}, // R2 highest ext
    '{32'h0008_000F, 32'h0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd30, 32'h4010_0000, 8'd3}, // R3 sw out of band
    '{32'h0, 32'h8008_0020, 5'd0,  1'b0, 1'b0, 1'b0, 5'd30, 32'h4010_0000, 8'd3}, // R3 ext out of band
    '{32'h0000_0010, 32'h0, 5'd0,  1'b1, 1'b0, 1'b1, 5'd30, 32'h4010_0000, 8'd7}, // R7 ast
    '{32'h0, 32'h0200_0000, 5'd31, 1'b0, 1'b0, 1'b0, 5'd30, 32'h4010_0000, 8'd4}, // R4 ipl max
    '{32'h0, 32'h0200_0000, 5'd24, 1'b0, 1'b1, 1'b0, 5'd25, 32'h0200_0000, 8'd5}, // R5 capture
    '{32'h0007_FFF0, 32'h7FF0_0000, 5'd0, 1'b0, 1'b1, 1'b0, 5'd30, 32'h7FF7_FFF0, 8'd3} // R3 all
  };

  task automatic check(string what, int rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(logic [31:0] sw, logic [31:0] ext, logic [4:0] ipl, logic ast);
    @(negedge clk);
    sw_req = sw; ext_req = ext; cur_ipl = ipl; ast_req = ast; rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    @(negedge clk);  // evaluating edge passed; sample here
  endtask

  initial begin
    sw_req = 32'h10; ext_req = 0; cur_ipl = 0; rearm = 0; ast_req = 0;
    repeat (3) @(negedge clk);
    // R9 reset values
    check("trap in reset", 9, {31'b0, trap}, 32'h0);
    check("summary in reset", 9, summary, 32'h0);
    check("intid in reset", 9, {27'b0, intid}, 32'h0);
    check("unsup in reset", 9, {31'b0, unsup}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R8 armed after reset: pending sw bit 4 resolved without rearm
    check("armed after reset id", 8, {27'b0, intid}, 32'd1);
    check("armed after reset sum", 8, summary, 32'h10);
    check("trap pulse ended", 6, {31'b0, trap}, 32'h0);
    sw_req = 0;

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i].sw, VECS[i].ext, VECS[i].ipl, VECS[i].ast);
      check($sformatf("vec%0d trap", i), VECS[i].req, {31'b0, trap}, {31'b0, VECS[i].e_trap});
      check($sformatf("vec%0d unsup", i), VECS[i].req, {31'b0, unsup}, {31'b0, VECS[i].e_unsup});
      check($sformatf("vec%0d intid", i), VECS[i].req, {27'b0, intid}, {27'b0, VECS[i].e_id});
      check($sformatf("vec%0d summary", i), VECS[i].req, summary, VECS[i].e_sum);
    end

    // R8: pending request without rearm is not evaluated
    @(negedge clk);
    sw_req = 0; ext_req = 32'h0200_0000; cur_ipl = 0; ast_req = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("no eval while disarmed", 8, {31'b0, trap}, 32'h0);
    end
    check("status held while disarmed", 8, {27'b0, intid}, 32'd30);

    // R6: trap is a one-cycle pulse
    run_vec(32'h0, 32'h0200_0000, 5'd0, 1'b0);
    check("pulse high", 6, {31'b0, trap}, 32'h1);
    check("pulse id", 6, {27'b0, intid}, 32'd25);
    @(negedge clk);
    check("pulse low next cycle", 6, {31'b0, trap}, 32'h0);

    // R4: nothing pending gives no trap even at ipl 0
    run_vec(32'h0, 32'h0, 5'd0, 1'b0);
    check("idle no trap", 4, {31'b0, trap}, 32'h0);
    check("idle hold sum", 5, summary, 32'h0200_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule